// File: doc/BRIEF.md
# Periodic Split-Transaction Scheduler

This block keeps the scheduling state of one periodic interrupt endpoint that sits behind a high-speed hub's transaction translator. At every micro-frame boundary it turns the low bits of the frame index into a one-hot micro-frame vector. It then compares that vector with the endpoint's start mask or completion mask and, in that cycle, raises a strobe telling the bus engine to send either a start-split or a complete-split.

The bus engine later reports one result for each attempt it was told to make. The scheduler uses that result to move between its two phases and to count consecutive errors. On the third consecutive error it halts the endpoint. The halt lasts until software clears it. Bus signalling, descriptor fetch and data movement are outside the block.

Top module: `split_sched`

## Requirements
- R1: When `uframe_start` is high, the micro-frame vector is 1 shifted left by `uframe_idx`; micro-frame 0 gives 8'b0000_0001. A strobe is raised only in a cycle with `uframe_start` high whose vector bit is set in the mask of the current phase.
- R2: In the start phase (`split_state`=0), a matching start-mask bit raises `issue_start` for exactly that cycle. The next cycle shows `split_state`=1 without waiting for any handshake.
- R3: In the complete phase (`split_state`=1), `issue_cmpl` is raised in every micro-frame whose bit is set in `cmpl_mask`. More than one bit may be set.
- R4: A result code 2'b11 (done) for an outstanding complete-split returns `split_state` to 0 and clears `err_count`.
- R5: A result code 2'b10 (not yet) changes neither `split_state` nor `err_count`.
- R6: A result code 2'b01 (error) increments `err_count`. When the count reaches 3, `halted` is set. While `halted` is set, `err_count` stays at 3 and results have no effect.
- R7: While `halted` is set, both strobes stay low. A `halt_clear` pulse clears `halted`, sets `err_count` to 0 and sets `split_state` to 0. When `halted` is low, `halt_clear` has no effect.
- R8: An error (2'b01) reported for an outstanding start-split returns `split_state` to 0 and increments `err_count`.
- R9: A result code 2'b00 (ok) for an outstanding complete-split clears `err_count` and keeps `split_state`=1. An ok or done result for a start-split changes nothing.
- R10: A result that arrives while no attempt is outstanding is ignored. In a cycle with `result_valid` high, no strobe is raised.
- R11: A synchronous reset sets `split_state` to 0, `err_count` to 0 and `halted` to 0, and clears any outstanding attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uframe_idx | input | 3 | Low bits of the frame index (current micro-frame) |
| uframe_start | input | 1 | One-cycle pulse at the start of a micro-frame |
| start_mask | input | 8 | Micro-frames allowed for the start-split |
| cmpl_mask | input | 8 | Micro-frames allowed for the complete-split |
| result_valid | input | 1 | A result for the outstanding attempt is present |
| result_code | input | 2 | 00 ok, 01 error, 10 not yet, 11 done |
| halt_clear | input | 1 | Software clear of the halted endpoint |
| issue_start | output | 1 | Send a start-split this micro-frame |
| issue_cmpl | output | 1 | Send a complete-split this micro-frame |
| split_state | output | 1 | 0 start phase, 1 complete phase |
| err_count | output | 2 | Consecutive error count |
| halted | output | 1 | Endpoint halted after the error limit |

## Verification
If the phase register is wrong, the wrong strobe appears at the next micro-frame whose bit is set in either mask. If the hidden outstanding-attempt flag is wrong, a result is applied when it should be dropped, or dropped when it should be applied, and `err_count` or `split_state` is off one cycle later. A behavioural model of phase, count, halt and outstanding attempt is compared with every output on every clock. A divergence is therefore reported in the cycle it first reaches a port, not when it eventually causes a halt.

// File: rtl/split_sched.sv
module split_sched #(
  parameter int UF_COUNT  = 8,
  parameter int ERR_LIMIT = 3,
  localparam int IW = $clog2(UF_COUNT),
  localparam int CW = $clog2(ERR_LIMIT + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IW-1:0]   uframe_idx,
  input  logic            uframe_start,
  input  logic [UF_COUNT-1:0] start_mask,
  input  logic [UF_COUNT-1:0] cmpl_mask,
  input  logic            result_valid,
  input  logic [1:0]      result_code,
  input  logic            halt_clear,
  output logic            issue_start,
  output logic            issue_cmpl,
  output logic            split_state,
  output logic [CW-1:0]   err_count,
  output logic            halted
);
  localparam logic [1:0] RES_OK = 2'b00, RES_ERR = 2'b01, RES_DONE = 2'b11;

  logic [UF_COUNT-1:0] uf_onehot;
  logic pending, pend_cmpl, may_issue;

  assign uf_onehot   = {{(UF_COUNT-1){1'b0}}, 1'b1} << uframe_idx;
  assign may_issue   = uframe_start & ~halted & ~result_valid;
  assign issue_start = may_issue & ~split_state & |(uf_onehot & start_mask);
  assign issue_cmpl  = may_issue &  split_state & |(uf_onehot & cmpl_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      split_state <= 1'b0;
      err_count   <= '0;
      halted      <= 1'b0;
      pending     <= 1'b0;
      pend_cmpl   <= 1'b0;
    end else if (halted) begin
      if (halt_clear) begin
        halted      <= 1'b0;
        err_count   <= '0;
        split_state <= 1'b0;
        pending     <= 1'b0;
      end
    end else if (result_valid && pending) begin
      pending <= 1'b0;
      if (result_code == RES_ERR) begin
        err_count <= err_count + CW'(1);
        if (err_count == CW'(ERR_LIMIT - 1)) halted <= 1'b1;
        if (!pend_cmpl) split_state <= 1'b0;
      end else if (pend_cmpl && result_code == RES_DONE) begin
        split_state <= 1'b0;
        err_count   <= '0;
      end else if (pend_cmpl && result_code == RES_OK) begin
        err_count <= '0;
      end
    end else if (issue_start) begin
      split_state <= 1'b1;
      pending     <= 1'b1;
      pend_cmpl   <= 1'b0;
    end else if (issue_cmpl) begin
      pending   <= 1'b1;
      pend_cmpl <= 1'b1;
    end
  end
endmodule

module split_sched_chk #(
  parameter int UF_COUNT  = 8,
  parameter int ERR_LIMIT = 3,
  localparam int IW = $clog2(UF_COUNT),
  localparam int CW = $clog2(ERR_LIMIT + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic [IW-1:0]   uframe_idx,
  input logic            uframe_start,
  input logic [UF_COUNT-1:0] start_mask,
  input logic [UF_COUNT-1:0] cmpl_mask,
  input logic            result_valid,
  input logic [1:0]      result_code,
  input logic            halt_clear,
  input logic            issue_start,
  input logic            issue_cmpl,
  input logic            split_state,
  input logic [CW-1:0]   err_count,
  input logic            halted
);
  // R1
  start_match_chk: assert property (@(posedge clk) disable iff (rst)
    issue_start |-> uframe_start && start_mask[uframe_idx] && !split_state);
  // R3
  cmpl_match_chk: assert property (@(posedge clk) disable iff (rst)
    issue_cmpl |-> uframe_start && cmpl_mask[uframe_idx] && split_state);
  // R2
  start_to_cmpl_chk: assert property (@(posedge clk) disable iff (rst)
    issue_start |=> split_state && !halted);
  // R7
  halted_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !issue_start && !issue_cmpl);
  // R6
  halt_count_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> err_count == CW'(ERR_LIMIT));
  // R6
  count_below_chk: assert property (@(posedge clk) disable iff (rst)
    !halted |-> err_count < CW'(ERR_LIMIT));
  // R10
  result_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> !issue_start && !issue_cmpl);
endmodule

bind split_sched split_sched_chk #(.UF_COUNT(UF_COUNT), .ERR_LIMIT(ERR_LIMIT)) u_chk (.*);

// File: tb/split_sched_test.sv
module split_sched_test;
  logic clk = 0, rst = 1;
  logic [2:0] uframe_idx = 0;
  logic uframe_start = 0, result_valid = 0, halt_clear = 0;
  logic [1:0] result_code = 0;
  logic [7:0] start_mask = 8'b0000_0010, cmpl_mask = 8'b0001_1000;
  logic issue_start, issue_cmpl, split_state, halted;
  logic [1:0] err_count;
  int checks = 0, failures = 0;
  string tag = "R11";
  int ms = 0, mc = 0, mh = 0, mp = 0, mk = 0;

  always #5 clk = ~clk;

  split_sched uut (.*);

  function automatic bit exp_s();
    return uframe_start && !mh && !result_valid && ms == 0 && start_mask[uframe_idx];
  endfunction
  function automatic bit exp_c();
    return uframe_start && !mh && !result_valid && ms == 1 && cmpl_mask[uframe_idx];
  endfunction

  always @(posedge clk) begin
    if (rst) begin ms = 0; mc = 0; mh = 0; mp = 0; mk = 0; end
    else if (mh) begin
      if (halt_clear) begin mh = 0; mc = 0; ms = 0; mp = 0; end
    end else if (result_valid && mp) begin
      mp = 0;
      if (result_code == 2'b01) begin
        mc = mc + 1;
        if (mc == 3) mh = 1;
        if (mk == 0) ms = 0;
      end else if (result_code == 2'b11 && mk == 1) begin ms = 0; mc = 0; end
      else if (result_code == 2'b00 && mk == 1) mc = 0;
    end else if (exp_s()) begin ms = 1; mp = 1; mk = 0; end
    else if (exp_c()) begin mp = 1; mk = 1; end
  end

  task automatic compare();
    int a, e;
    a = {issue_start, issue_cmpl, split_state, err_count, halted};
    e = {exp_s(), exp_c(), ms[0], mc[1:0], mh[0]};
    checks++;
    if (a != e) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b (start,cmpl,state,count,halted)", tag, a[5:0], e[5:0]);
    end
  endtask

  task automatic cyc(input logic [2:0] i, input logic us, input logic rv, input logic [1:0] rc, input logic cl);
    uframe_idx = i; uframe_start = us; result_valid = rv; result_code = rc; halt_clear = cl;
    @(negedge clk);
    compare();
    @(posedge clk);
    #1;
  endtask

  task automatic frame(input logic [2:0] i); cyc(i, 1, 0, 0, 0); cyc(0, 0, 0, 0, 0); endtask
  task automatic res(input logic [1:0] c); cyc(0, 0, 1, c, 0); endtask

  task automatic expect_val(input int a, input int e, input string t);
    checks++;
    if (a != e) begin failures++; $display("FAIL %s actual=%0d expected=%0d", t, a, e); end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL R11 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cyc(0, 0, 0, 0, 0);
    rst = 0;
    #1;
    expect_val({split_state, err_count, halted}, 0, "R11 reset state");
    tag = "R1"; frame(0); frame(2); frame(3);
    tag = "R10"; res(2'b01); cyc(1, 1, 1, 2'b00, 0);
    expect_val(err_count, 0, "R10 stray result ignored");
    expect_val(split_state, 0, "R10 no start with result");
    tag = "R2"; frame(1);
    expect_val(split_state, 1, "R2 moves to complete phase");
    tag = "R8"; res(2'b01);
    expect_val({split_state, err_count}, 1, "R8 start error");
    tag = "R1"; frame(3); frame(1);
    tag = "R3"; frame(3);
    tag = "R5"; res(2'b10);
    expect_val({split_state, err_count}, 3'b101, "R5 not-yet unchanged");
    tag = "R3"; frame(4); res(2'b01);
    expect_val(err_count, 2, "R6 count increments");
    frame(3);
    tag = "R9"; res(2'b00);
    expect_val({split_state, err_count}, 3'b100, "R9 ok clears count");
    frame(4);
    tag = "R4"; res(2'b11);
    expect_val({split_state, err_count}, 0, "R4 done back to start");
    tag = "R7"; cyc(0, 0, 0, 0, 1);
    expect_val(split_state, 0, "R7 clear ignored when not halted");
    tag = "R6"; frame(1); res(2'b01); frame(1); frame(3); res(2'b01); frame(4); res(2'b01);
    expect_val({halted, err_count}, 3'b111, "R6 third error halts");
    tag = "R7"; frame(3); frame(4); frame(1); res(2'b11);
    expect_val({halted, err_count}, 3'b111, "R7 halted ignores results");
    cyc(0, 0, 0, 0, 1);
    expect_val({split_state, err_count, halted}, 0, "R7 clear restores");
    start_mask = 8'b1000_0001; cmpl_mask = 8'b0110_0000;
    tag = "R1"; frame(0);
    expect_val(split_state, 1, "R1 micro-frame 0 matches bit 0");
    tag = "R3"; frame(5); res(2'b10); frame(6); res(2'b11);
    tag = "R11"; frame(7); rst = 1; cyc(0, 0, 0, 0, 0); rst = 0;
    expect_val({split_state, err_count, halted}, 0, "R11 reset mid-split");
    res(2'b01);
    expect_val(err_count, 0, "R11 reset dropped outstanding attempt");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule